// File: doc/BRIEF.md
# Prefetch Burst Serializer with Beat Ordering

This block sits between a wide memory array word and a narrow pin interface that moves data in bursts. The array delivers or accepts a word of eight beats (8×N bits for an N-bit pin width) in a single core access. On a read command the block loads that whole word at once and then sends it out one beat per beat-clock cycle. The order of the beats follows the three low column address bits and a sequential or interleaved burst type. A chop mode sends only four of the eight beats.

On a write command the block collects beats from the pin side in natural order. It then presents one wide word together with a per-lane write enable and the array word address. The upper column bits select the array word, so a 10-bit column address addresses 128 words. A single-edge beat clock stands in for the double-data-rate pin clock. Bursts can follow one another with no idle cycle between them.

The burst length comes from a configuration input. It can be fixed at eight beats, fixed at four beats, or chosen per command when the on-the-fly setting is active.

Top module: `pbs_burst_serdes`

## Requirements
- R1: A write reports the array word address as column bits [9:3] on `wr_addr`; column bits [2:0] never change that address.
- R2: With `cmd_interleave`=0 (sequential), read beat i (i = 0..7) carries array lane ((s[1:0]+i) mod 4) + 4·(s[2] XOR (i≥4)), where s = column bits [2:0] and lane k is `rd_word[8k+7:8k]` for the default width.
- R3: With `cmd_interleave`=1, read beat i carries lane s XOR i; when s = 0 both burst types give lanes 0..7 in natural order.
- R4: `cfg_len_mode` encoding: 0 is fixed eight beats, 1 is fixed four beats (chop), and 2 or 3 is on-the-fly, where `cmd_chop`=1 selects four beats and 0 selects eight. In the fixed modes `cmd_chop` is ignored. A chopped read emits the first four beats of the selected order, which stay within the half-word that holds the start lane.
- R5: `out_valid` is high only on emitted read beats. After a chopped read, the four remaining lanes are never driven as valid. `out_data` is zero whenever `out_valid` is low.
- R6: `out_last` is high exactly on the final beat of a read burst, and `out_valid` stays high from the first beat of a burst to its last.
- R7: `cmd_ready` is high when the block is idle or on the final beat of a burst. The first beat of an accepted read appears in the cycle after acceptance, so back-to-back bursts have no gap.
- R8: A command presented while `cmd_ready` is low is refused. It does not disturb the running burst, and no burst starts for it.
- R9: A write takes beats from `in_data` in the cycles after acceptance, in natural lane order starting at lane 0, whatever column bits [2:0] hold. One cycle after the final beat is sampled, `wr_valid` pulses for one cycle with `wr_word` and `wr_lane_en`. The enable is all ones for eight beats, or 0x0F for a chopped write, and unwritten lanes read as zero.
- R10: Reset (active-low `rst_n`, asynchronous) returns the block to idle: `out_valid`, `out_last` and `wr_valid` are low and `cmd_ready` is high.
- R11: During a write burst `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len_mode | input | 2 | Burst length mode (R4 encoding) |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_col | input | COL_W (10) | Column address |
| cmd_interleave | input | 1 | 1 = interleaved order, 0 = sequential |
| cmd_chop | input | 1 | Per-command chop select for on-the-fly mode |
| rd_word | input | 8·PIN_W (64) | Array word for a read, sampled at acceptance |
| out_data | output | PIN_W (8) | Read beat data |
| out_valid | output | 1 | Read beat valid |
| out_last | output | 1 | Final beat of a read burst |
| in_data | input | PIN_W (8) | Write beat data |
| wr_valid | output | 1 | Gathered write word ready (one-cycle pulse) |
| wr_addr | output | COL_W-3 (7) | Array word address of the write |
| wr_word | output | 8·PIN_W (64) | Gathered write word |
| wr_lane_en | output | 8 | Per-lane write enable |

## Verification
A wrong start lane, burst type or beat counter shows on `out_data` in the very first beat after acceptance. A corrupted length decision shows as `out_last` or a drop of `out_valid` four beats too early or too late. A stale busy flag shows at the end of a burst: either `cmd_ready` stays low, which leaves a gap before the next burst, or the refused command leaks through as an extra burst. Write-side faults surface one cycle after the final beat, as a wrong lane in `wr_word`, a wrong enable mask or a wrong address.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    // Beats moved per array access (8n prefetch)
    localparam int PREFETCH_BEATS = 8;

    typedef enum logic [1:0] {
        LEN_BL8     = 2'd0,
        LEN_BC4     = 2'd1,
        LEN_OTF     = 2'd2,
        LEN_OTF_ALT = 2'd3
    } len_mode_e;

endpackage

// File: rtl/pbs_len_select.sv
module pbs_len_select (
    input  logic [1:0] mode,
    input  logic       cmd_chop,
    output logic       chop
);
    import pbs_pkg::*;

    always_comb begin
        case (len_mode_e'(mode))
            LEN_BL8: chop = 1'b0;
            LEN_BC4: chop = 1'b1;
            default: chop = cmd_chop;   // both on-the-fly encodings
        endcase
    end
endmodule

// File: rtl/pbs_beat_order.sv
module pbs_beat_order #(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] start,
    input  logic             interleave,
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] lane
);
    logic [IDX_W-2:0] wrap_low;
    logic [IDX_W-1:0] seq_lane;
    logic [IDX_W-1:0] int_lane;

    // sequential: wrap inside the half-word, swap halves for the second four
    assign wrap_low = start[IDX_W-2:0] + idx[IDX_W-2:0];
    assign seq_lane = {start[IDX_W-1] ^ idx[IDX_W-1], wrap_low};
    assign int_lane = start ^ idx;
    assign lane     = interleave ? int_lane : seq_lane;
endmodule

// File: rtl/pbs_lane_mux.sv
module pbs_lane_mux #(
    parameter int PIN_W = 8,
    parameter int BEATS = 8,
    parameter int IDX_W = 3
) (
    input  logic [BEATS*PIN_W-1:0] word,
    input  logic [IDX_W-1:0]       sel,
    output logic [PIN_W-1:0]       lane
);
    logic [PIN_W-1:0] lanes [BEATS];

    for (genvar g = 0; g < BEATS; g++) begin : g_lane
        assign lanes[g] = word[g*PIN_W +: PIN_W];
    end

    assign lane = lanes[sel];
endmodule

// File: rtl/pbs_burst_serdes.sv
module pbs_burst_serdes #(
    parameter int PIN_W = 8,
    parameter int COL_W = 10
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [1:0]                                 cfg_len_mode,
    input  logic                                       cmd_valid,
    output logic                                       cmd_ready,
    input  logic                                       cmd_write,
    input  logic [COL_W-1:0]                           cmd_col,
    input  logic                                       cmd_interleave,
    input  logic                                       cmd_chop,
    input  logic [pbs_pkg::PREFETCH_BEATS*PIN_W-1:0]   rd_word,
    output logic [PIN_W-1:0]                           out_data,
    output logic                                       out_valid,
    output logic                                       out_last,
    input  logic [PIN_W-1:0]                           in_data,
    output logic                                       wr_valid,
    output logic [COL_W-$clog2(pbs_pkg::PREFETCH_BEATS)-1:0] wr_addr,
    output logic [pbs_pkg::PREFETCH_BEATS*PIN_W-1:0]   wr_word,
    output logic [pbs_pkg::PREFETCH_BEATS-1:0]         wr_lane_en
);
    localparam int BEATS  = pbs_pkg::PREFETCH_BEATS;
    localparam int HALF   = BEATS / 2;
    localparam int IDX_W  = $clog2(BEATS);
    localparam int WORD_W = BEATS * PIN_W;
    localparam int ADDR_W = COL_W - IDX_W;

    localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(BEATS - 1);
    localparam logic [IDX_W-1:0] LAST_CHOP = IDX_W'(HALF - 1);
    localparam logic [BEATS-1:0] MASK_FULL = '1;
    localparam logic [BEATS-1:0] MASK_CHOP = {{HALF{1'b0}}, {HALF{1'b1}}};

    typedef struct packed {
        logic              busy;
        logic              write;
        logic              chop;
        logic              inter;
        logic [IDX_W-1:0]  start;
        logic [IDX_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] word;
        logic              wr_valid;
        logic [WORD_W-1:0] wr_word;
        logic [BEATS-1:0]  wr_lane;
        logic [ADDR_W-1:0] wr_addr;
    } state_t;

    state_t st_q, st_d;

    logic             cmd_chop_sel;
    logic [IDX_W-1:0] lane_sel;
    logic [PIN_W-1:0] lane_data;
    logic             at_end;
    logic             accept;

    pbs_len_select len_sel_i (
        .mode     (cfg_len_mode),
        .cmd_chop (cmd_chop),
        .chop     (cmd_chop_sel)
    );

    pbs_beat_order #(.IDX_W(IDX_W)) order_i (
        .start      (st_q.start),
        .interleave (st_q.inter),
        .idx        (st_q.cnt),
        .lane       (lane_sel)
    );

    pbs_lane_mux #(.PIN_W(PIN_W), .BEATS(BEATS), .IDX_W(IDX_W)) mux_i (
        .word (st_q.word),
        .sel  (lane_sel),
        .lane (lane_data)
    );

    assign at_end    = st_q.busy && (st_q.cnt == (st_q.chop ? LAST_CHOP : LAST_FULL));
    assign cmd_ready = !st_q.busy || at_end;
    assign accept    = cmd_valid && cmd_ready;

    assign out_valid  = st_q.busy && !st_q.write;
    assign out_data   = out_valid ? lane_data : '0;
    assign out_last   = out_valid && at_end;
    assign wr_valid   = st_q.wr_valid;
    assign wr_addr    = st_q.wr_addr;
    assign wr_word    = st_q.wr_word;
    assign wr_lane_en = st_q.wr_lane;

    always_comb begin
        st_d          = st_q;
        st_d.wr_valid = 1'b0;

        // gather a write beat into its natural lane
        if (st_q.busy && st_q.write) begin
            for (int b = 0; b < BEATS; b++) begin
                if (st_q.cnt == IDX_W'(b)) begin
                    st_d.word[b*PIN_W +: PIN_W] = in_data;
                end
            end
        end

        if (st_q.busy) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (at_end) begin
            st_d.busy = 1'b0;
            if (st_q.write) begin
                st_d.wr_valid = 1'b1;
                st_d.wr_word  = st_d.word;
                st_d.wr_lane  = st_q.chop ? MASK_CHOP : MASK_FULL;
                st_d.wr_addr  = st_q.addr;
            end
        end

        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.write = cmd_write;
            st_d.chop  = cmd_chop_sel;
            st_d.inter = cmd_interleave;
            st_d.start = cmd_write ? '0 : cmd_col[IDX_W-1:0];
            st_d.cnt   = '0;
            st_d.addr  = cmd_col[COL_W-1:IDX_W];
            st_d.word  = cmd_write ? '0 : rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pbs_burst_serdes_chk.sv
module pbs_burst_serdes_chk #(
    parameter int PIN_W = 8,
    parameter int BEATS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             cmd_write,
    input logic [PIN_W-1:0] out_data,
    input logic             out_valid,
    input logic             out_last,
    input logic             wr_valid,
    input logic [BEATS-1:0] wr_lane_en
);
    assert_last_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_burst_continues_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    assert_quiet_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0));

    assert_busy_refuses_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> !cmd_ready);

    assert_read_starts_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_write) |=> out_valid);

    assert_wr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    assert_wr_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($countones(wr_lane_en) == BEATS || $countones(wr_lane_en) == BEATS / 2));
endmodule

bind pbs_burst_serdes pbs_burst_serdes_chk #(.PIN_W(PIN_W), .BEATS(BEATS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_write  (cmd_write),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .wr_valid   (wr_valid),
    .wr_lane_en (wr_lane_en)
);

// File: tb/pbs_burst_serdes_tb_top.sv
module pbs_burst_serdes_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PIN_W = 8;
    localparam int COL_W = 10;
    localparam int BEATS = 8;
    localparam int WORD_W = PIN_W * BEATS;

    // {col[9:0], interleave, mode[1:0], chop, lane order (nibble i = lane of beat i), length}
    localparam int NVEC = 10;
    localparam logic [49:0] VECS [NVEC] = '{
        {10'h000, 1'b0, 2'd0, 1'b0, 32'h76543210, 4'd8},
        {10'h045, 1'b0, 2'd0, 1'b0, 32'h03214765, 4'd8},
        {10'h0AD, 1'b1, 2'd0, 1'b0, 32'h23016745, 4'd8},
        {10'h13B, 1'b0, 2'd2, 1'b0, 32'h65472103, 4'd8},
        {10'h2FE, 1'b1, 2'd0, 1'b0, 32'h10325476, 4'd8},
        {10'h0F2, 1'b0, 2'd1, 1'b0, 32'h00001032, 4'd4},
        {10'h3FF, 1'b1, 2'd2, 1'b1, 32'h00004567, 4'd4},
        {10'h011, 1'b0, 2'd3, 1'b0, 32'h47650321, 4'd8},
        {10'h1C4, 1'b1, 2'd1, 1'b0, 32'h00007654, 4'd4},
        {10'h200, 1'b1, 2'd0, 1'b1, 32'h76543210, 4'd8}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_len_mode = 2'd0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic              cmd_write = 1'b0;
    logic [COL_W-1:0]  cmd_col = '0;
    logic              cmd_interleave = 1'b0;
    logic              cmd_chop = 1'b0;
    logic [WORD_W-1:0] rd_word = '0;
    logic [PIN_W-1:0]  out_data;
    logic              out_valid;
    logic              out_last;
    logic [PIN_W-1:0]  in_data = '0;
    logic              wr_valid;
    logic [COL_W-4:0]  wr_addr;
    logic [WORD_W-1:0] wr_word;
    logic [BEATS-1:0]  wr_lane_en;

    int  tests = 0;
    int  failed = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbs_burst_serdes #(.PIN_W(PIN_W), .COL_W(COL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_len_mode(cfg_len_mode),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_col(cmd_col), .cmd_interleave(cmd_interleave), .cmd_chop(cmd_chop),
        .rd_word(rd_word), .out_data(out_data), .out_valid(out_valid),
        .out_last(out_last), .in_data(in_data), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_word(wr_word), .wr_lane_en(wr_lane_en)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] pattern(input logic [7:0] base);
        logic [WORD_W-1:0] w;
        for (int k = 0; k < BEATS; k++) w[k*PIN_W +: PIN_W] = base + 8'(k);
        return w;
    endfunction

    // Present a read command at a negedge; returns after the accepting posedge
    task automatic issue_read(input logic [9:0] col, input logic inter, input logic [1:0] mode,
                              input logic chop, input logic [7:0] base);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = col;
        cmd_interleave = inter; cfg_len_mode = mode; cmd_chop = chop;
        rd_word = pattern(base);
        chk("R7 ready before accept", 64'(cmd_ready), 64'd1);
        @(posedge clk);
    endtask

    task automatic check_beats(input logic [31:0] order, input int len, input logic [7:0] base);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            chk("R5 valid on beat", 64'(out_valid), 64'd1);
            chk("R2 R3 R4 beat lane", 64'(out_data), 64'(base + 8'(order[i*4 +: 4])));
            chk("R6 last flag", 64'(out_last), 64'(i == len - 1));
        end
    endtask

    task automatic check_idle(input string req);
        @(negedge clk);
        chk(req, {62'd0, out_valid, |out_data}, 64'd0);
    endtask

    task automatic run_write(input logic [9:0] col, input logic [1:0] mode, input logic chop,
                             input int len);
        logic [WORD_W-1:0] exp_w;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_col = col;
        cfg_len_mode = mode; cmd_chop = chop; cmd_interleave = 1'b0;
        @(posedge clk);
        exp_w = '0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            in_data = 8'hC0 + 8'(i);
            exp_w[i*PIN_W +: PIN_W] = 8'hC0 + 8'(i);
            chk("R11 no read data during write", 64'(out_valid), 64'd0);
            @(posedge clk);
        end
        @(negedge clk);
        chk("R9 wr_valid pulse", 64'(wr_valid), 64'd1);
        chk("R9 gathered word", 64'(wr_word), 64'(exp_w));
        chk("R9 lane enable", 64'(wr_lane_en), (len == 8) ? 64'hFF : 64'h0F);
        chk("R1 write address", 64'(wr_addr), 64'(col[9:3]));
        @(negedge clk);
        chk("R9 pulse ends", 64'(wr_valid), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            tests++;
            failed++;
            $display("[TB] watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        #(CLK_PERIOD * 2 + 1);
        chk("R10 reset out_valid", 64'(out_valid), 64'd0);
        chk("R10 reset out_last", 64'(out_last), 64'd0);
        chk("R10 reset wr_valid", 64'(wr_valid), 64'd0);
        chk("R10 reset ready", 64'(cmd_ready), 64'd1);
        @(negedge clk);
        rst_n = 1'b1;

        // table of read vectors
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            issue_read(VECS[v][49:40], VECS[v][39], VECS[v][38:37], VECS[v][36], 8'hA0);
            check_beats(VECS[v][35:4], int'(VECS[v][3:0]), 8'hA0);
            check_idle("R5 R4 no extra beats after burst");
        end

        // R7 back-to-back, R8 refusal mid-burst
        @(negedge clk);
        issue_read(10'h000, 1'b0, 2'd0, 1'b0, 8'hA0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            chk("R6 first burst lane", 64'(out_data), 64'(8'hA0 + 8'(i)));
            if (i == 7) begin
                cmd_valid = 1'b1; cmd_col = 10'h002; cmd_interleave = 1'b1;
                rd_word = pattern(8'h50);
                chk("R7 ready on last beat", 64'(cmd_ready), 64'd1);
                @(posedge clk);
            end
        end
        begin
            logic [31:0] ord2;
            ord2 = 32'h54761032;   // interleaved from lane 2
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                cmd_valid = 1'b0;
                if (i == 0) chk("R7 no gap between bursts", 64'(out_valid), 64'd1);
                chk("R3 R8 second burst lane", 64'(out_data), 64'(8'h50 + 8'(ord2[i*4 +: 4])));
                if (i == 2) begin
                    cmd_valid = 1'b1; cmd_col = 10'h007; cmd_interleave = 1'b0;
                    rd_word = pattern(8'h10);
                    chk("R8 refused while busy", 64'(cmd_ready), 64'd0);
                end
            end
            check_idle("R8 refused command started nothing");
        end

        // writes: nonzero start ignored; chopped write
        run_write({7'd9, 3'd5}, 2'd0, 1'b0, 8);
        run_write({7'd100, 3'd6}, 2'd2, 1'b1, 4);

        // R10: reset mid-burst
        @(negedge clk);
        issue_read(10'h010, 1'b0, 2'd0, 1'b0, 8'hA0);
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R10 mid-burst reset valid", 64'(out_valid), 64'd0);
        chk("R10 mid-burst reset ready", 64'(cmd_ready), 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        check_idle("R10 idle after reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule